// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block arbitrates interrupt requests for a small processor core. Each source has an enable bit held in the controller, and one global enable gates them all. Sources come in two kinds, chosen per source by a parameter mask. Event sources latch a pending flag. Level sources request only while their input is high and are never remembered.

At each instruction-boundary strobe from the core, the controller looks at the enabled pending requests and picks the one with the lowest source index. It raises a one-cycle take pulse together with the vector address for that source. In the same edge it clears the global enable and the winning flag.

A return strobe turns the global enable back on. The controller then lets exactly one instruction boundary pass before it may take again. A select input moves the vector table from address zero to a parameterised boot base.

Top module: `vic_top`

## Requirements
- R1: After reset the global enable is 0, all enables and flags are 0, `irq_take` is 0 and `irq_vector` is 0.
- R2: A source is taken only if its enable bit and the global enable are both 1.
- R3: When several enabled sources are pending, the lowest index wins. `irq_vector` = base + 2*(index+1), and `irq_idx` = index.
- R4: An event flag stays set while its source is disabled or the global enable is 0. The flag is taken once both enables are set.
- R5: The edge that takes a source clears the global enable and clears that source's event flag.
- R6: A write on `flag_clr_wr` clears each flag whose bit in `flag_clr_mask` is 1 and leaves flags whose mask bit is 0. A new event in the same cycle wins over the clear.
- R7: A level source (its bit is 1 in LEVEL_MASK) sets no flag. It requests only while `src_req` is high, and it is lost if it drops before it is enabled.
- R8: `reti` sets the global enable. The first boundary strobe after `reti` never takes, and the second one can.
- R9: `gie_clr` clears the global enable at once and blocks a take on a boundary in the same cycle.
- R10: A take happens only on a cycle with `insn_bnd` high. `irq_take` is a one-cycle pulse, registered on that clock edge.
- R11: With `boot_sel` at 1 the vector base is BOOT_BASE, and with `boot_sel` at 0 it is 0.
- R12: `gie_set` inside a handler turns the global enable back on, so a further pending source can be taken (nesting).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| src_req | input | NUM_SRC | requests: a one-cycle event for flag sources, a held level for level sources |
| en_wr | input | 1 | load the enable register |
| en_wdata | input | NUM_SRC | new enable bits |
| flag_clr_wr | input | 1 | write-one-to-clear strobe for the flags |
| flag_clr_mask | input | NUM_SRC | flags to clear |
| gie_set | input | 1 | set the global enable |
| gie_clr | input | 1 | clear the global enable, effective immediately |
| reti | input | 1 | return-from-interrupt strobe |
| insn_bnd | input | 1 | instruction-boundary strobe from the core |
| boot_sel | input | 1 | selects the boot base for the vector table |
| irq_take | output | 1 | one-cycle pulse: vector taken |
| irq_vector | output | PC_W | vector address of the taken source |
| irq_idx | output | IDX_W | index of the taken source |
| gie_o | output | 1 | current global enable |
| flags_o | output | NUM_SRC | current event flags |

## Verification
The bench sweeps every combination of the six event flags. A wrong priority chain would return some other vector, and a missed hardware clear would leave the winning flag set. It covers a return followed at once by two boundaries; a design without the one-instruction hold would take on the first boundary. It drives a global disable on the same cycle as a boundary, which a design with a registered disable would still take. It also drops a level source before enabling it; if the design latched that source, a take would appear that should not.

// File: rtl/vic_pkg.sv
package vic_pkg;
  // Offset of a source slot in the vector table: slots are two words wide,
  // slot 0 holds the reset entry.
  function automatic logic [31:0] vic_slot_offset(input int unsigned idx);
    return 32'((idx + 1) * 2);
  endfunction
endpackage

// File: rtl/vic_prio_pick.sv
module vic_prio_pick #(
  parameter int unsigned NUM_SRC = 8,
  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] req,
  output logic [NUM_SRC-1:0] grant,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  logic [NUM_SRC:0] seen;
  assign seen[0] = 1'b0;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chain
    assign grant[g]  = req[g] & ~seen[g];
    assign seen[g+1] = seen[g] | req[g];
  end

  assign any = seen[NUM_SRC];

  always_comb begin
    idx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (grant[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/vic_src_bank.sv
module vic_src_bank #(
  parameter int unsigned      NUM_SRC    = 8,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic               en_wr,
  input  logic [NUM_SRC-1:0] en_wdata,
  input  logic               clr_wr,
  input  logic [NUM_SRC-1:0] clr_mask,
  input  logic               take_fire,
  input  logic [NUM_SRC-1:0] take_grant,
  output logic [NUM_SRC-1:0] flag_q,
  output logic [NUM_SRC-1:0] pending
);
  logic [NUM_SRC-1:0] en_q, en_d, flag_d, evt_set;

  assign evt_set = src_req & ~LEVEL_MASK;
  assign pending = (flag_q | (src_req & LEVEL_MASK)) & en_q;

  always_comb begin
    en_d   = en_wr ? en_wdata : en_q;
    flag_d = flag_q;
    if (clr_wr)    flag_d = flag_d & ~clr_mask;
    if (take_fire) flag_d = flag_d & ~take_grant;
    flag_d = (flag_d | evt_set) & ~LEVEL_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      en_q   <= en_d;
      flag_q <= flag_d;
    end
  end

  AST_TAKEN_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (take_fire && ((take_grant & src_req) == '0)) |=> ((flag_q & $past(take_grant)) == '0)); // R5
  AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_wr && !take_fire) |=> ((flag_q & $past(flag_q)) == $past(flag_q))); // R4
endmodule

// File: rtl/vic_seq.sv
module vic_seq #(
  parameter int unsigned    PC_W      = 16,
  parameter int unsigned    IDX_W     = 3,
  parameter logic [PC_W-1:0] BOOT_BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_bnd,
  input  logic              any_pend,
  input  logic [IDX_W-1:0]  win_idx,
  input  logic              gie_set,
  input  logic              gie_clr,
  input  logic              reti,
  input  logic              boot_sel,
  output logic              fire,
  output logic              gie_q,
  output logic              take_q,
  output logic [PC_W-1:0]   vec_q,
  output logic [IDX_W-1:0]  idx_q
);
  import vic_pkg::*;

  logic            hold_q, hold_d, gie_d;
  logic [PC_W-1:0] vec_d, base;
  logic [IDX_W-1:0] idx_d;

  assign base = boot_sel ? BOOT_BASE : '0;
  assign fire = insn_bnd & gie_q & ~gie_clr & ~hold_q & ~reti & any_pend;

  always_comb begin
    gie_d  = gie_q;
    if (reti || gie_set) gie_d = 1'b1;
    if (fire || gie_clr) gie_d = 1'b0;
    hold_d = hold_q;
    if (insn_bnd) hold_d = 1'b0;
    if (reti)     hold_d = 1'b1;
    vec_d  = vec_q;
    idx_d  = idx_q;
    if (fire) begin
      vec_d = base + PC_W'(vic_slot_offset(int'(win_idx)));
      idx_d = win_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q  <= 1'b0;
      hold_q <= 1'b0;
      take_q <= 1'b0;
      vec_q  <= '0;
      idx_q  <= '0;
    end else begin
      gie_q  <= gie_d;
      hold_q <= hold_d;
      take_q <= fire;
      vec_q  <= vec_d;
      idx_q  <= idx_d;
    end
  end

  AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |-> $past(insn_bnd)); // R10
  AST_TAKE_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |-> !gie_q); // R5
  AST_DISABLE_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    gie_clr |=> !take_q); // R9
  AST_RETI_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    reti |=> !take_q); // R8
  AST_HOLD_ONE_INSN: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && insn_bnd) |=> !take_q); // R8
  AST_RETI_SETS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !gie_clr) |=> gie_q); // R8
endmodule

// File: rtl/vic_top.sv
module vic_top #(
  parameter int unsigned        NUM_SRC    = 8,
  parameter int unsigned        PC_W       = 16,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = 8'hC0,
  parameter logic [PC_W-1:0]    BOOT_BASE  = 16'h1E00,
  localparam int unsigned       IDX_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic               en_wr,
  input  logic [NUM_SRC-1:0] en_wdata,
  input  logic               flag_clr_wr,
  input  logic [NUM_SRC-1:0] flag_clr_mask,
  input  logic               gie_set,
  input  logic               gie_clr,
  input  logic               reti,
  input  logic               insn_bnd,
  input  logic               boot_sel,
  output logic               irq_take,
  output logic [PC_W-1:0]    irq_vector,
  output logic [IDX_W-1:0]   irq_idx,
  output logic               gie_o,
  output logic [NUM_SRC-1:0] flags_o
);
  logic [NUM_SRC-1:0] pending, grant;
  logic               any_pend, fire;
  logic [IDX_W-1:0]   win_idx;

  vic_src_bank #(.NUM_SRC(NUM_SRC), .LEVEL_MASK(LEVEL_MASK)) i_bank (
    .clk(clk), .rst_n(rst_n), .src_req(src_req),
    .en_wr(en_wr), .en_wdata(en_wdata),
    .clr_wr(flag_clr_wr), .clr_mask(flag_clr_mask),
    .take_fire(fire), .take_grant(grant),
    .flag_q(flags_o), .pending(pending)
  );

  vic_prio_pick #(.NUM_SRC(NUM_SRC)) i_pick (
    .req(pending), .grant(grant), .any(any_pend), .idx(win_idx)
  );

  vic_seq #(.PC_W(PC_W), .IDX_W(IDX_W), .BOOT_BASE(BOOT_BASE)) i_seq (
    .clk(clk), .rst_n(rst_n), .insn_bnd(insn_bnd), .any_pend(any_pend),
    .win_idx(win_idx), .gie_set(gie_set), .gie_clr(gie_clr), .reti(reti),
    .boot_sel(boot_sel), .fire(fire), .gie_q(gie_o), .take_q(irq_take),
    .vec_q(irq_vector), .idx_q(irq_idx)
  );

  AST_SINGLE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> ($countones(grant) == 1)); // R3
  AST_TAKE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (gie_o && pending != '0)); // R2
endmodule

// File: tb/test_vic_top.sv
`timescale 1ns/1ps
module test_vic_top;
  localparam int unsigned N = 8;
  localparam int unsigned PC_W = 16;
  localparam logic [N-1:0] LVL = 8'hC0;
  localparam logic [PC_W-1:0] BOOT = 16'h1E00;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] src_pulse, src_lvl, src_req;
  logic en_wr, flag_clr_wr, gie_set, gie_clr, reti, insn_bnd, boot_sel;
  logic [N-1:0] en_wdata, flag_clr_mask;
  logic irq_take, gie_o;
  logic [PC_W-1:0] irq_vector;
  logic [2:0] irq_idx;
  logic [N-1:0] flags_o;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  assign src_req = src_pulse | src_lvl;
  always #2.5 clk = ~clk;

  vic_top #(.NUM_SRC(N), .PC_W(PC_W), .LEVEL_MASK(LVL), .BOOT_BASE(BOOT)) i_vic_top (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .en_wr(en_wr), .en_wdata(en_wdata),
    .flag_clr_wr(flag_clr_wr), .flag_clr_mask(flag_clr_mask), .gie_set(gie_set),
    .gie_clr(gie_clr), .reti(reti), .insn_bnd(insn_bnd), .boot_sel(boot_sel),
    .irq_take(irq_take), .irq_vector(irq_vector), .irq_idx(irq_idx),
    .gie_o(gie_o), .flags_o(flags_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock: inputs applied before the edge, results sampled 1 ns after it
  task automatic tick();
    @(posedge clk);
    #1;
    src_pulse = '0; en_wr = 0; flag_clr_wr = 0; gie_set = 0; gie_clr = 0;
    reti = 0; insn_bnd = 0;
  endtask

  function automatic int low_bit(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  initial begin
    #1000000;
    n_fail++; n_chk++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; src_pulse = '0; src_lvl = '0; en_wr = 0; en_wdata = '0;
    flag_clr_wr = 0; flag_clr_mask = '0; gie_set = 0; gie_clr = 0; reti = 0;
    insn_bnd = 0; boot_sel = 0;
    #12 rst_n = 1;
    tick();
    // R1 reset state
    chk(irq_take == 0 && gie_o == 0, "R1 take/gie", {irq_take, gie_o}, 0);
    chk(flags_o == 0 && irq_vector == 0, "R1 flags/vector", int'(flags_o), 0);
    // R2 / R4: flag pending but source disabled
    src_pulse = 8'h08; gie_set = 1; tick();
    insn_bnd = 1; tick();
    chk(irq_take == 0, "R2 disabled source taken", irq_take, 0);
    chk(flags_o == 8'h08, "R4 flag held while disabled", int'(flags_o), 8'h08);
    gie_clr = 1; en_wr = 1; en_wdata = 8'hFF; tick();
    insn_bnd = 1; tick();
    chk(irq_take == 0, "R2 global off taken", irq_take, 0);
    chk(flags_o == 8'h08, "R4 flag held while masked", int'(flags_o), 8'h08);
    // R10: no take without a boundary
    gie_set = 1; tick(); tick(); tick();
    chk(irq_take == 0, "R10 take without boundary", irq_take, 0);
    insn_bnd = 1; tick();
    chk(irq_take == 1 && irq_vector == 16'd8, "R4 serviced once enabled", int'(irq_vector), 8);
    tick();
    chk(irq_take == 0, "R10 take pulse width", irq_take, 0);
    // R12 nesting: handler sets gie, another source taken
    src_pulse = 8'h04; tick();
    insn_bnd = 1; tick();
    chk(irq_take == 0, "R12 no take with gie off", irq_take, 0);
    gie_set = 1; tick();
    insn_bnd = 1; tick();
    chk(irq_take == 1 && irq_idx == 2, "R12 nested take", int'(irq_idx), 2);
    // R8: return hold
    src_pulse = 8'h02; tick();
    reti = 1; tick();
    chk(gie_o == 1, "R8 reti sets gie", gie_o, 1);
    insn_bnd = 1; tick();
    chk(irq_take == 0, "R8 first boundary after reti", irq_take, 0);
    insn_bnd = 1; tick();
    chk(irq_take == 1 && irq_vector == 16'd4, "R8 second boundary takes", int'(irq_vector), 4);
    // R9: disable in the same cycle as a boundary
    src_pulse = 8'h01; gie_set = 1; tick();
    insn_bnd = 1; gie_clr = 1; tick();
    chk(irq_take == 0 && gie_o == 0, "R9 same-cycle disable", {irq_take, gie_o}, 0);
    chk(flags_o == 8'h01, "R9 flag kept", int'(flags_o), 1);
    // R6: write one to clear
    src_pulse = 8'h0E; tick();
    flag_clr_wr = 1; flag_clr_mask = 8'h05; tick();
    chk(flags_o == 8'h0A, "R6 selective clear", int'(flags_o), 8'h0A);
    flag_clr_wr = 1; flag_clr_mask = 8'h00; tick();
    chk(flags_o == 8'h0A, "R6 zero mask no effect", int'(flags_o), 8'h0A);
    flag_clr_wr = 1; flag_clr_mask = 8'h02; src_pulse = 8'h02; tick();
    chk(flags_o == 8'h0A, "R6 event beats clear", int'(flags_o), 8'h0A);
    flag_clr_wr = 1; flag_clr_mask = 8'hFF; tick();
    // R7: level source lost before enable
    en_wr = 1; en_wdata = 8'h3F; src_lvl = 8'h40; tick(); tick();
    src_lvl = 8'h00; en_wr = 1; en_wdata = 8'hFF; gie_set = 1; tick();
    insn_bnd = 1; tick();
    chk(irq_take == 0 && flags_o == 0, "R7 level not latched", int'(flags_o), 0);
    src_lvl = 8'hC0; insn_bnd = 1; tick();
    chk(irq_take == 1 && irq_vector == 16'd14, "R7 level taken while high", int'(irq_vector), 14);
    chk(flags_o == 0, "R7 no flag for level", int'(flags_o), 0);
    src_lvl = '0;
    // R3 / R5 / R11: sweep every flag pattern on the six event sources
    for (int p = 1; p < 64; p++) begin
      automatic logic [N-1:0] pat = N'(p);
      automatic int lb = low_bit(pat);
      automatic logic bs = (p % 3 == 0);
      automatic int base = bs ? int'(BOOT) : 0;
      src_pulse = pat; gie_set = 1; boot_sel = bs; tick();
      insn_bnd = 1; tick();
      chk(irq_take == 1 && int'(irq_vector) == base + 2 * (lb + 1),
          bs ? "R11 boot-base vector" : "R3 priority vector", int'(irq_vector), base + 2 * (lb + 1));
      chk(int'(irq_idx) == lb, "R3 winner index", int'(irq_idx), lb);
      chk(gie_o == 0 && flags_o == (pat & ~(N'(1) << lb)), "R5 gie and flag cleared",
          int'(flags_o), int'(pat & ~(N'(1) << lb)));
      flag_clr_wr = 1; flag_clr_mask = 8'hFF; tick();
    end
    boot_sel = 0;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule